// File: doc/BRIEF.md
# Power-State Sequencer with Mains-Loss Recovery

This block keeps track of which of three system power states is active: full power, suspend (processor off, memory still supplied) and soft off (memory unpowered as well). Requests to suspend, to switch off and to wake arrive as level inputs. Each cycle the block either accepts one of them, ignores it, or rejects it when the move is not permitted. From the current state it drives two rail enables: one for the main supplies and one for the memory supply.

A wake from soft off never jumps straight to full power. It passes through the suspend state for `WAKE_CYC` clock cycles, and this hold is not a state that the system can rest in. While mains power is absent, the block holds soft off. When mains returns, a two-bit policy input decides what happens next: stay off, come back on, or restore what was in force before the loss. A retained bit records that last state.

Top module: `pwr_state_seq`

## Requirements
- R1: While reset is held and after its release with mains absent, `state` reads 2'b10 (soft off), both rail enables are low and `req_err` is low.
- R2: The rails decode from `state`. Code 2'b00 (full power) drives `main_en`=1 and `mem_en`=1. Code 2'b01 (suspend) drives `main_en`=0 and `mem_en`=1. Code 2'b10 (soft off) drives both low.
- R3: In full power, `req_off` moves to soft off and takes precedence over `req_sleep`. `req_sleep` alone moves to suspend. `req_wake` is ignored and raises no error.
- R4: In suspend, `req_wake` moves to full power on the next clock edge. It takes precedence over `req_off`.
- R5: In suspend, `req_off` without `req_wake` is rejected. The state stays suspend and `req_err` is high in the cycle after each rejected edge. A direct move from suspend to soft off never happens while mains is present.
- R6: In soft off, `req_wake` shows suspend for exactly `WAKE_CYC` cycles and then full power. All requests are ignored during this pass-through.
- R7: In soft off, `req_sleep` without `req_wake` is rejected with a `req_err` pulse, and the state stays soft off.
- R8: While `ac_ok` is low, the state is forced to soft off on the next edge from any state. Requests are ignored and `req_err` stays low.
- R9: On the first edge that sees `ac_ok` high after it was low, `policy` is evaluated once. 2'b01 (always on) starts the wake pass-through. 2'b00 (always off) and 2'b11 leave the state at soft off.
- R10: With `policy`=2'b10 (keep last), the wake pass-through starts when mains returns only if the retained bit is set. The bit is set on entering full power and cleared when `req_off` leaves full power. Mains loss does not change it, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_sleep | input | 1 | Request to enter suspend |
| req_off | input | 1 | Request to enter soft off |
| req_wake | input | 1 | Request to return to full power |
| ac_ok | input | 1 | Mains present |
| policy | input | 2 | Recovery policy: 00 off, 01 on, 10 keep last, 11 off |
| state | output | 2 | Current state: 00 full, 01 suspend, 10 soft off |
| main_en | output | 1 | Main rail enable |
| mem_en | output | 1 | Memory rail enable |
| req_err | output | 1 | One-cycle flag for a rejected request |

## Verification
Every request, mains change and policy decision takes effect on the first rising edge that samples it. The new state, the rail enables and `req_err` all become visible together in the cycle after that edge. The wake pass-through holds suspend for exactly `WAKE_CYC` cycles from the starting edge. The bench drives inputs on falling edges and samples outputs on the next falling edge, which is half a cycle after the edge that made the change. It then walks the pass-through one cycle at a time and expects full power on cycle `WAKE_CYC`+1.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    ST_ON   = 2'b00,
    ST_SUSP = 2'b01,
    ST_OFF  = 2'b10,
    ST_BAD  = 2'b11
  } pstate_t;

  typedef enum logic [2:0] {
    DEC_NONE,
    DEC_TO_ON,
    DEC_TO_SUSP,
    DEC_TO_OFF,
    DEC_WAKE_SEQ,
    DEC_REJECT
  } dec_t;

  localparam logic [1:0] POL_OFF  = 2'b00;
  localparam logic [1:0] POL_ON   = 2'b01;
  localparam logic [1:0] POL_LAST = 2'b10;

  // main rail enable, memory rail enable
  function automatic logic [1:0] f_rails(input pstate_t s);
    case (s)
      ST_ON:   f_rails = 2'b11;
      ST_SUSP: f_rails = 2'b01;
      default: f_rails = 2'b00;
    endcase
  endfunction

  function automatic logic f_policy_wakes(input logic [1:0] pol, input logic last_on);
    case (pol)
      POL_ON:   f_policy_wakes = 1'b1;
      POL_LAST: f_policy_wakes = last_on;
      default:  f_policy_wakes = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pss_req_arb.sv
module pss_req_arb
  import pss_pkg::*;
(
  input  pstate_t st,
  input  logic    req_sleep,
  input  logic    req_off,
  input  logic    req_wake,
  output dec_t    dec
);

  always_comb begin
    dec = DEC_NONE;
    case (st)
      ST_ON: begin
        if (req_off)        dec = DEC_TO_OFF;
        else if (req_sleep) dec = DEC_TO_SUSP;
      end
      ST_SUSP: begin
        if (req_wake)       dec = DEC_TO_ON;
        else if (req_off)   dec = DEC_REJECT;
      end
      ST_OFF: begin
        if (req_wake)       dec = DEC_WAKE_SEQ;
        else if (req_sleep) dec = DEC_REJECT;
      end
      default:              dec = DEC_TO_OFF;
    endcase
  end

endmodule

// File: rtl/pss_wake_timer.sv
module pss_wake_timer #(
  parameter int WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);

  localparam int CW = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  assign busy = active_q;
  assign done = active_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (abort) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (done) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  // R6
  wake_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q <= LAST));

  // R6
  wake_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (cnt_q == '0));

endmodule

// File: rtl/pss_recovery.sv
module pss_recovery
  import pss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ac_ok,
  input  logic [1:0] policy,
  input  logic       set_last,
  input  logic       clr_last,
  output logic       ac_rise,
  output logic       resume_wake,
  output logic       last_on
);

  logic ac_q;
  logic last_q;

  assign ac_rise     = ac_ok && !ac_q;
  assign resume_wake = ac_rise && f_policy_wakes(policy, last_q);
  assign last_on     = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      ac_q <= ac_ok;
      if (set_last)      last_q <= 1'b1;
      else if (clr_last) last_q <= 1'b0;
    end
  end

  // R9
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ac_rise |=> !ac_rise);

  // R10
  last_hold_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_ok |=> (last_q == $past(last_q)));

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pss_pkg::*;
#(
  parameter int WAKE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_sleep,
  input  logic       req_off,
  input  logic       req_wake,
  input  logic       ac_ok,
  input  logic [1:0] policy,
  output logic [1:0] state,
  output logic       main_en,
  output logic       mem_en,
  output logic       req_err
);

  pstate_t state_q, state_d;
  logic    err_q, err_d;
  dec_t    dec;

  logic ac_rise, resume_wake, last_on;
  logic wake_busy, wake_done;
  logic wake_start, wake_abort;
  logic set_last, clr_last;
  logic normal_ev, reject_ev;

  pss_req_arb u_arb (
    .st        (state_q),
    .req_sleep (req_sleep),
    .req_off   (req_off),
    .req_wake  (req_wake),
    .dec       (dec)
  );

  pss_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wake_start),
    .abort (wake_abort),
    .busy  (wake_busy),
    .done  (wake_done)
  );

  pss_recovery u_rec (
    .clk         (clk),
    .rst_n       (rst_n),
    .ac_ok       (ac_ok),
    .policy      (policy),
    .set_last    (set_last),
    .clr_last    (clr_last),
    .ac_rise     (ac_rise),
    .resume_wake (resume_wake),
    .last_on     (last_on)
  );

  // requests are only acted on with mains steady and no pass-through running
  assign normal_ev  = ac_ok && !ac_rise && !wake_busy;
  assign reject_ev  = normal_ev && (dec == DEC_REJECT);
  assign wake_abort = !ac_ok;
  assign wake_start = resume_wake || (normal_ev && dec == DEC_WAKE_SEQ);

  always_comb begin
    state_d = state_q;
    if (!ac_ok) begin
      state_d = ST_OFF;
    end else if (ac_rise) begin
      state_d = resume_wake ? ST_SUSP : ST_OFF;
    end else if (wake_busy) begin
      if (wake_done) state_d = ST_ON;
    end else begin
      case (dec)
        DEC_TO_ON:    state_d = ST_ON;
        DEC_TO_SUSP:  state_d = ST_SUSP;
        DEC_TO_OFF:   state_d = ST_OFF;
        DEC_WAKE_SEQ: state_d = ST_SUSP;
        default:      state_d = state_q;
      endcase
    end
  end

  assign err_d    = reject_ev;
  assign set_last = ac_ok && (state_d == ST_ON) && (state_q != ST_ON);
  assign clr_last = ac_ok && (state_d == ST_OFF) && (state_q == ST_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign state             = state_q;
  assign {main_en, mem_en} = f_rails(state_q);
  assign req_err           = err_q;

  // R2
  rails_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_en |-> mem_en);

  // R5
  no_susp_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP && ac_ok) |=> (state_q != ST_OFF));

  // R5
  err_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (state_q == $past(state_q)));

  // R8
  ac_loss_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_ok |=> (state_q == ST_OFF && !req_err));

  // R10
  last_on_in_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON) |-> last_on);

  // R3
  reject_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |-> (state_q != ST_ON));

endmodule

// File: tb/pwr_state_seq_tb.sv
module pwr_state_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WAKE_CYC   = 4;
  localparam logic [1:0] S_FULL = 2'b00, S_SUSP = 2'b01, S_OFF = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_sleep = 1'b0, req_off = 1'b0, req_wake = 1'b0;
  logic       ac_ok = 1'b0;
  logic [1:0] policy = 2'b00;
  logic [1:0] state;
  logic       main_en, mem_en, req_err;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_seq #(.WAKE_CYC(WAKE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_sleep(req_sleep), .req_off(req_off),
    .req_wake(req_wake), .ac_ok(ac_ok), .policy(policy), .state(state),
    .main_en(main_en), .mem_en(mem_en), .req_err(req_err)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [1:0] es, input logic ee);
    logic em, ek;
    em = (es == S_FULL);
    ek = (es == S_FULL) || (es == S_SUSP);
    checks++;
    if (state !== es || main_en !== em || mem_en !== ek || req_err !== ee) begin
      failures++;
      $display("FAIL %s: state=%b main=%b mem=%b err=%b expected state=%b main=%b mem=%b err=%b",
               tag, state, main_en, mem_en, req_err, es, em, ek, ee);
    end
  endtask

  task automatic set_req(input logic s, input logic o, input logic w);
    req_sleep = s; req_off = o; req_wake = w;
  endtask

  // state must be the first pass-through cycle now
  task automatic walk_wake(input string tag);
    chk(tag, S_SUSP, 1'b0);
    for (int i = 1; i < WAKE_CYC; i++) begin
      tick();
      chk(tag, S_SUSP, 1'b0);
    end
    tick();
    chk(tag, S_FULL, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 in reset", S_OFF, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk("R1 after reset", S_OFF, 1'b0);
  endtask

  task automatic t_no_mains();
    set_req(1'b1, 1'b0, 1'b1);
    tick();
    chk("R8 requests ignored without mains", S_OFF, 1'b0);
    set_req(0, 0, 0);
  endtask

  task automatic t_policy_off();
    policy = 2'b00; ac_ok = 1'b1;
    tick();
    chk("R9 always-off stays off", S_OFF, 1'b0);
    tick();
    chk("R9 always-off still off", S_OFF, 1'b0);
  endtask

  task automatic t_off_reject();
    set_req(1, 0, 0);
    tick();
    chk("R7 sleep rejected in soft off", S_OFF, 1'b1);
    set_req(0, 0, 0);
    tick();
    chk("R7 error clears", S_OFF, 1'b0);
  endtask

  task automatic t_wake_from_off();
    set_req(0, 0, 1);
    tick();
    set_req(0, 1, 0);  // ignored during pass-through (R6)
    walk_wake("R6 wake pass-through");
    set_req(0, 0, 0);
  endtask

  task automatic t_full_moves();
    set_req(0, 0, 1);
    tick();
    chk("R3 wake ignored in full power", S_FULL, 1'b0);
    set_req(1, 1, 0);
    tick();
    chk("R3 off beats sleep", S_OFF, 1'b0);
    set_req(0, 0, 1);
    tick();
    set_req(0, 0, 0);
    walk_wake("R6 second wake");
    set_req(1, 0, 0);
    tick();
    chk("R3 sleep to suspend", S_SUSP, 1'b0);
    set_req(0, 0, 0);
  endtask

  task automatic t_susp_moves();
    set_req(0, 1, 0);
    tick();
    chk("R5 off rejected in suspend", S_SUSP, 1'b1);
    tick();
    chk("R5 still suspend, error repeats while held", S_SUSP, 1'b1);
    set_req(0, 0, 0);
    tick();
    chk("R5 error clears", S_SUSP, 1'b0);
    set_req(0, 1, 1);
    tick();
    chk("R4 wake beats off in suspend", S_FULL, 1'b0);
    set_req(1, 0, 0);
    tick();
    set_req(0, 0, 1);
    tick();
    chk("R4 wake from suspend", S_FULL, 1'b0);
    set_req(0, 0, 0);
  endtask

  task automatic t_keep_last();
    policy = 2'b10;
    ac_ok = 1'b0;
    tick();
    chk("R8 mains loss from full", S_OFF, 1'b0);
    set_req(0, 0, 1);
    tick();
    chk("R8 wake ignored without mains", S_OFF, 1'b0);
    set_req(0, 0, 0);
    ac_ok = 1'b1;
    tick();
    walk_wake("R10 keep-last restores on");
    set_req(0, 1, 0);
    tick();
    chk("R10 off clears last state", S_OFF, 1'b0);
    set_req(0, 0, 0);
    ac_ok = 1'b0; tick();
    ac_ok = 1'b1; tick();
    chk("R10 keep-last stays off", S_OFF, 1'b0);
    tick();
    chk("R10 keep-last stays off later", S_OFF, 1'b0);
  endtask

  task automatic t_policy_on_and_bad();
    policy = 2'b01;
    ac_ok = 1'b0; tick();
    ac_ok = 1'b1; tick();
    walk_wake("R9 always-on wakes");
    set_req(1, 0, 0); tick(); set_req(0, 0, 0);
    chk("R2 suspend rails", S_SUSP, 1'b0);
    ac_ok = 1'b0; tick();
    chk("R8 mains loss from suspend", S_OFF, 1'b0);
    policy = 2'b11;
    ac_ok = 1'b1; tick();
    chk("R9 policy 11 stays off", S_OFF, 1'b0);
    policy = 2'b10;
    ac_ok = 1'b0; tick();
    ac_ok = 1'b1; tick();
    chk("R10 bit kept through loss from suspend", S_SUSP, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done_flag) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_no_mains();
    t_policy_off();
    t_off_reject();
    t_wake_from_off();
    t_full_moves();
    t_susp_moves();
    t_keep_last();
    t_policy_on_and_bad();
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule